// File: doc/BRIEF.md
# Paged Program Sequencer with One-Entry Return Stack

This block produces the program ROM address for a small 4-bit controller whose program store holds 2048 nine-bit words, arranged as 16 pages of 128 words. The address is the concatenation of a 4-bit current page and a 7-bit in-page offset. The offset counter steps by one for each instruction. When it passes 127 it returns to 0, and the page does not change. To leave a page, software first writes a target page into a page buffer. A later taken branch or call then moves that buffered value into the current page and loads the offset with the instruction's 7-bit target.

Subroutine linkage uses a single saved slot. A call with an empty slot records the address of the following instruction, then jumps. A call with the slot already occupied jumps only and keeps the older entry. A return restores the saved page and offset and frees the slot. A return with nothing saved advances like any other instruction. Branches and calls are taken only when the status flag is high.

The instruction decoder drives the strobes. A cycle-enable input marks the one clock in each instruction period on which the sequencer acts.

Top module: `paged_seq`

## Requirements
- R1: After reset the address output is 0x780 (page 15, offset 0), the page buffer holds 15 and the return slot is empty. A taken branch issued straight after reset therefore stays on page 15.
- R2: While `step_en` is low, the address, the page buffer and the return slot keep their values, whatever strobes are asserted.
- R3: An instruction that is not a taken transfer or a return adds one to the offset. From offset 127 the offset goes to 0 and the page is unchanged.
- R4: A load-page instruction writes `page_imm` into the page buffer, advances the offset and leaves the current page unchanged.
- R5: A taken branch (`do_branch` with `status` = 1) sets the page to the buffer contents and the offset to `target`.
- R6: A branch or call with `status` = 0 behaves as a plain advance and leaves the return slot unchanged.
- R7: A taken call with an empty slot saves the current page together with offset+1 (wrapping 127 to 0 within the page), marks the slot full and then jumps as in R5.
- R8: A taken call with the slot already full jumps as in R5 and leaves the saved entry and the full mark unchanged.
- R9: A return with the slot full sets the address output to the saved page and offset and empties the slot.
- R10: A return with the slot empty behaves as a plain advance.
- R11: When several strobes are high together, return takes priority over call, call over branch, and branch over load-page. A strobe that loses is ignored, so a branch that wins over a load-page leaves the page buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | High on the one clock of each instruction period that updates state |
| do_ldp | input | 1 | Load-page strobe |
| page_imm | input | 4 | Page value written by load-page |
| do_branch | input | 1 | Branch strobe |
| do_call | input | 1 | Call strobe |
| do_ret | input | 1 | Return strobe |
| target | input | 7 | In-page target offset for branch and call |
| status | input | 1 | Status flag; a transfer is taken only when it is 1 |
| rom_addr | output | 11 | ROM address {page, offset} |

## Verification
The assertions assume that the strobes and `target`, `page_imm` and `status` are stable and known at every clock edge where `step_en` is high. They also assume that the reset synchroniser has released before any strobe is sampled. The bench changes inputs only on falling edges and waits several clocks after reset release before issuing the first instruction. Several strobes are deliberately driven together only in the priority scenario and in the `step_en`-low scenario. In both cases the expected result comes from the fixed ordering in R11 or from the hold rule in R2.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  // Resolved action for one instruction step.
  typedef enum logic [2:0] {
    ACT_ADV  = 3'd0,
    ACT_LDP  = 3'd1,
    ACT_JUMP = 3'd2,
    ACT_CALL = 3'd3,
    ACT_POP  = 3'd4
  } seq_act_e;

endpackage

// File: rtl/pseq_rst_sync.sv
module pseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pseq_decode.sv
module pseq_decode
  import pseq_pkg::*;
(
  input  logic     do_ldp,
  input  logic     do_branch,
  input  logic     do_call,
  input  logic     do_ret,
  input  logic     status,
  input  logic     slot_full,
  output seq_act_e act
);

  // Fixed priority: return, call, branch, load-page, advance.
  always_comb begin
    act = ACT_ADV;
    if (do_ret) begin
      act = slot_full ? ACT_POP : ACT_ADV;
    end else if (do_call) begin
      if (status) act = slot_full ? ACT_JUMP : ACT_CALL;
    end else if (do_branch) begin
      if (status) act = ACT_JUMP;
    end else if (do_ldp) begin
      act = ACT_LDP;
    end
  end

endmodule

// File: rtl/pseq_offset.sv
module pseq_offset
  import pseq_pkg::*;
#(
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  seq_act_e         act,
  input  logic [OFF_W-1:0] target,
  input  logic [OFF_W-1:0] saved_off,
  output logic [OFF_W-1:0] off_q,
  output logic [OFF_W-1:0] off_inc
);

  localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};

  logic [OFF_W-1:0] off_d;

  assign off_inc = OFF_W'(off_q + 1'b1);

  always_comb begin
    off_d = off_q;
    if (step_en) begin
      unique case (act)
        ACT_JUMP, ACT_CALL: off_d = target;
        ACT_POP:            off_d = saved_off;
        default:            off_d = off_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  // R3: the last offset of a page advances to zero
  assert_offset_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (act == ACT_ADV || act == ACT_LDP) && off_q == OFF_LAST) |=> (off_q == '0));

  // R2: no step, no movement
  assert_offset_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(off_q));

endmodule

// File: rtl/pseq_page.sv
module pseq_page
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  seq_act_e          act,
  input  logic [PAGE_W-1:0] page_imm,
  input  logic [PAGE_W-1:0] saved_page,
  output logic [PAGE_W-1:0] page_q,
  output logic [PAGE_W-1:0] pbuf_q
);

  localparam logic [PAGE_W-1:0] PAGE_RST = {PAGE_W{1'b1}};

  logic [PAGE_W-1:0] page_d;
  logic [PAGE_W-1:0] pbuf_d;

  always_comb begin
    page_d = page_q;
    pbuf_d = pbuf_q;
    if (step_en) begin
      unique case (act)
        ACT_LDP:            pbuf_d = page_imm;
        ACT_JUMP, ACT_CALL: page_d = pbuf_q;
        ACT_POP:            page_d = saved_page;
        default:            ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PAGE_RST;
      pbuf_q <= PAGE_RST;
    end else begin
      page_q <= page_d;
      pbuf_q <= pbuf_d;
    end
  end

  // R4: load-page leaves the current page alone
  assert_ldp_keeps_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && act == ACT_LDP) |=> $stable(page_q));

  // R3: a plain advance never changes page
  assert_adv_keeps_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && act == ACT_ADV) |=> $stable(page_q));

  // R5: a jump lands on the buffered page
  assert_jump_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (act == ACT_JUMP || act == ACT_CALL)) |=> (page_q == $past(pbuf_q)));

endmodule

// File: rtl/pseq_slot.sv
module pseq_slot
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  seq_act_e          act,
  input  logic [PAGE_W-1:0] cur_page,
  input  logic [OFF_W-1:0]  next_off,
  output logic              full_q,
  output logic [PAGE_W-1:0] sv_page_q,
  output logic [OFF_W-1:0]  sv_off_q
);

  logic              full_d;
  logic [PAGE_W-1:0] sv_page_d;
  logic [OFF_W-1:0]  sv_off_d;

  always_comb begin
    full_d    = full_q;
    sv_page_d = sv_page_q;
    sv_off_d  = sv_off_q;
    if (step_en) begin
      if (act == ACT_CALL) begin
        full_d    = 1'b1;
        sv_page_d = cur_page;
        sv_off_d  = next_off;
      end else if (act == ACT_POP) begin
        full_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      sv_page_q <= '0;
      sv_off_q  <= '0;
    end else begin
      full_q    <= full_d;
      sv_page_q <= sv_page_d;
      sv_off_q  <= sv_off_d;
    end
  end

  // R8: nested call keeps the older entry
  assert_nested_keeps_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && act == ACT_JUMP && full_q) |=> (full_q && $stable(sv_page_q) && $stable(sv_off_q)));

  // R9: a return empties the slot
  assert_pop_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && act == ACT_POP) |=> !full_q);

  // R7: a first call always fills the slot
  assert_call_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && act == ACT_CALL) |=> full_q);

endmodule

// File: rtl/paged_seq.sv
module paged_seq
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    do_ldp,
  input  logic [PAGE_W-1:0]       page_imm,
  input  logic                    do_branch,
  input  logic                    do_call,
  input  logic                    do_ret,
  input  logic [OFF_W-1:0]        target,
  input  logic                    status,
  output logic [PAGE_W+OFF_W-1:0] rom_addr
);

  logic              srst_n;
  seq_act_e          act;
  logic              slot_full;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] pbuf_q;
  logic [PAGE_W-1:0] sv_page;
  logic [OFF_W-1:0]  sv_off;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  off_inc;

  pseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (srst_n)
  );

  pseq_decode u_decode (
    .do_ldp    (do_ldp),
    .do_branch (do_branch),
    .do_call   (do_call),
    .do_ret    (do_ret),
    .status    (status),
    .slot_full (slot_full),
    .act       (act)
  );

  pseq_offset #(.OFF_W(OFF_W)) u_offset (
    .clk       (clk),
    .rst_n     (srst_n),
    .step_en   (step_en),
    .act       (act),
    .target    (target),
    .saved_off (sv_off),
    .off_q     (off_q),
    .off_inc   (off_inc)
  );

  pseq_page #(.PAGE_W(PAGE_W)) u_page (
    .clk        (clk),
    .rst_n      (srst_n),
    .step_en    (step_en),
    .act        (act),
    .page_imm   (page_imm),
    .saved_page (sv_page),
    .page_q     (page_q),
    .pbuf_q     (pbuf_q)
  );

  pseq_slot #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_slot (
    .clk       (clk),
    .rst_n     (srst_n),
    .step_en   (step_en),
    .act       (act),
    .cur_page  (page_q),
    .next_off  (off_inc),
    .full_q    (slot_full),
    .sv_page_q (sv_page),
    .sv_off_q  (sv_off)
  );

  assign rom_addr = {page_q, off_q};

  // R6: a transfer with status low leaves the page where it was
  assert_untaken_page_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && !do_ret && (do_branch || do_call) && !status)
      |=> (rom_addr[PAGE_W+OFF_W-1:OFF_W] == $past(rom_addr[PAGE_W+OFF_W-1:OFF_W])));

  // R2: address frozen without a step
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !step_en |=> $stable(rom_addr));

  // R10: return on empty slot is a plain increment within the page
  assert_empty_ret_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && do_ret && !slot_full)
      |=> (rom_addr == {$past(rom_addr[PAGE_W+OFF_W-1:OFF_W]),
                        OFF_W'($past(rom_addr[OFF_W-1:0]) + 1'b1)}));

endmodule

// File: tb/paged_seq_bench.sv
module paged_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, do_ldp, do_branch, do_call, do_ret, status;
  logic [3:0]  page_imm;
  logic [6:0]  target;
  logic [10:0] rom_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  paged_seq u_paged_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .do_ldp    (do_ldp),
    .page_imm  (page_imm),
    .do_branch (do_branch),
    .do_call   (do_call),
    .do_ret    (do_ret),
    .target    (target),
    .status    (status),
    .rom_addr  (rom_addr)
  );

  task automatic check(input string req, input logic [10:0] exp);
    checks++;
    if (rom_addr !== exp) begin
      errors++;
      $display("FAIL %s: rom_addr=0x%03h expected=0x%03h", req, rom_addr, exp);
    end
  endtask

  // One instruction slot: drive at falling edge, sample just after rising edge.
  task automatic step(input logic en, input logic l, input logic [3:0] pv,
                      input logic b, input logic c, input logic r,
                      input logic [6:0] t, input logic s);
    @(negedge clk);
    step_en = en; do_ldp = l; page_imm = pv; do_branch = b;
    do_call = c; do_ret = r; target = t; status = s;
    @(posedge clk);
    #1;
    @(negedge clk);
    step_en = 0; do_ldp = 0; do_branch = 0; do_call = 0; do_ret = 0;
  endtask

  task automatic adv();                      step(1,0,4'd0,0,0,0,7'd0,1); endtask
  task automatic ldp(input logic [3:0] p);   step(1,1,p,0,0,0,7'd0,1);    endtask
  task automatic br(input logic [6:0] t, input logic s);   step(1,0,4'd0,1,0,0,t,s); endtask
  task automatic call(input logic [6:0] t, input logic s); step(1,0,4'd0,0,1,0,t,s); endtask
  task automatic ret();                      step(1,0,4'd0,0,0,1,7'd0,1); endtask

  task automatic t_reset();
    check("R1 reset address", 11'h780);
    br(7'h22, 1);
    check("R1 buffer resets to 15", 11'h7A2);
  endtask

  task automatic t_advance_hold();
    for (int i = 0; i < 3; i++) adv();
    check("R3 advance", 11'h7A5);
    step(0,1,4'd3,1,1,0,7'h10,1);
    check("R2 hold without step_en", 11'h7A5);
    br(7'h00, 1);
    check("R2 buffer untouched while idle", 11'h780);
  endtask

  task automatic t_wrap();
    ldp(4'd5);
    br(7'd126, 1);
    check("R5 branch to page 5", 11'h2FE);
    adv();
    check("R3 offset 127", 11'h2FF);
    adv();
    check("R3 wrap keeps page", 11'h280);
  endtask

  task automatic t_ldp_branch();
    ldp(4'd9);
    check("R4 load-page keeps page", 11'h281);
    br(7'h10, 1);
    check("R5 branch uses buffer", 11'h490);
  endtask

  task automatic t_untaken();
    ldp(4'd3);
    br(7'h00, 0);
    check("R6 branch status 0", 11'h492);
    call(7'h00, 0);
    check("R6 call status 0", 11'h493);
    ret();
    check("R6 R10 no entry was saved", 11'h494);
  endtask

  task automatic t_calls();
    ldp(4'd2);
    call(7'h40, 1);
    check("R7 call jumps", 11'h140);
    ldp(4'd4);
    call(7'h07, 1);
    check("R8 nested call jumps", 11'h207);
    ret();
    check("R8 R9 return to first caller", 11'h496);
    ret();
    check("R10 return on empty slot", 11'h497);
  endtask

  task automatic t_call_wrap();
    ldp(4'd6);
    br(7'd126, 1);
    ldp(4'd1);
    check("R7 call site at 127", 11'h37F);
    call(7'h05, 1);
    check("R7 call to page 1", 11'h085);
    ret();
    check("R7 saved offset wraps", 11'h300);
  endtask

  task automatic t_priority();
    ldp(4'd2);
    call(7'h00, 1);
    check("R11 setup call", 11'h100);
    step(1,1,4'd7,1,1,1,7'h55,1);
    check("R11 return wins", 11'h302);
    step(1,1,4'd7,1,0,0,7'h11,1);
    check("R11 branch beats load-page", 11'h111);
    br(7'h00, 1);
    check("R11 buffer not loaded", 11'h100);
  endtask

  initial begin
    rst_n = 0; step_en = 0; do_ldp = 0; do_branch = 0; do_call = 0;
    do_ret = 0; status = 0; page_imm = 0; target = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_advance_hold();
    t_wrap();
    t_ldp_branch();
    t_untaken();
    t_calls();
    t_call_wrap();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule